// File: doc/BRIEF.md
# Multi-way Rendezvous Arbiter

This block lets several small state machines on one shared clock take transitions together. Each machine raises one request bit for every table entry it is ready to join. It supplies an output value and a guard window for each of those entries. The table of entries is fixed by parameters. An entry names its participants and whether it is a transfer or an agreement. A transfer entry names one producer, whose value must lie in the entry's type domain and inside the guard window of every consumer. An agreement entry has only output participants, and it requires that all their values are equal. Entries can be declared mutually exclusive, and entries that share a participant are always exclusive.

All entries are evaluated combinationally in the same cycle. A rotating-priority selector then grants a set of entries in which no two conflict. Registered outputs follow on the next edge: per-entry fire bits, a one-cycle fire strobe for every machine in a granted entry, and the transferred value latched into that machine's receive register. Transitions on gates outside the table use separate solo request bits and are never arbitrated. The block has no back-pressure: a strobe tells a machine that its transition committed, and the machine must drop or change its request before the next cycle. Holding a request makes the entry fire again.

Top module: `rdv_arbiter`

## Requirements
- R1: After reset, all fire strobes, entry fire bits and solo strobes are low, every receive register is zero, and the rotation pointer starts at entry 0.
- R2: An entry is executable only when every participant has its request bit set. Request bit for machine m and entry e is `req[m*N_ENT+e]`, and values and guard bounds use slice `(m*N_ENT+e)*DW`. When an entry fires, every participant and no other machine gets a one-cycle fire strobe on the clock edge after the request cycle.
- R3: A transfer entry is executable only if the producer's value v satisfies DOM_LO ≤ v ≤ DOM_HI of that entry (entry e uses bits `e*DW` of each domain map).
- R4: A transfer entry is executable only if, for every consumer c, `grd_lo ≤ v ≤ grd_hi` for c on that entry. Bounds are inclusive.
- R5: An agreement entry (bit e of AGREE_MAP set) is executable only if the values of all participants are equal. The transferred value is that common value.
- R6: When machine m fires, `rx_data[m*DW +: DW]` is loaded with the entry's transferred value. For a transfer entry this is the producer's value. In all other cycles, `rx_data` for m holds its value.
- R7: Two entries that are listed as conflicting in CONF_MAP (either direction), or that share a participant, never fire in the same cycle. Executable entries that do not conflict fire together.
- R8: Selection scans entries from the rotation pointer upward and wraps around. It grants each executable entry that does not conflict with one already granted. The pointer then moves to one past the first entry granted, and it is unchanged when nothing is granted.
- R9: `solo_fire[m]` equals `solo_req[m]` one cycle later, regardless of any table activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_MACH*N_ENT | Per-machine, per-entry request bits |
| val | input | N_MACH*N_ENT*DW | Per-machine, per-entry output value |
| grd_lo | input | N_MACH*N_ENT*DW | Inclusive lower guard bound for a receiving machine |
| grd_hi | input | N_MACH*N_ENT*DW | Inclusive upper guard bound for a receiving machine |
| solo_req | input | N_MACH | Requests on gates outside the table |
| fire | output | N_MACH | One-cycle commit strobe per machine |
| ent_fire | output | N_ENT | Entries granted in the previous cycle |
| rx_data | output | N_MACH*DW | Latched received value per machine |
| solo_fire | output | N_MACH | Registered copy of solo_req |

## Verification
The bench targets value boundaries: a producer value exactly at the domain and guard limits, and one step beyond them. A design with an off-by-one comparison would fire or refuse at exactly those points. It drives two explicitly exclusive entries together over several cycles, and two entries that only share a machine. A design that ignored the conflict set or did not rotate would fire both, or would let one entry win every time. An agreement entry with unequal values, a missing participant, and a granted pair of disjoint entries expose designs that fire on partial readiness or serialise entries that are independent. A long random phase compares strobes and receive registers against a reference model, and it catches receive registers that change when no strobe was given.

// File: rtl/rdv_pkg.sv
package rdv_pkg;

  // index of the lowest set bit of a participant mask (0 when empty)
  function automatic int low_bit(input logic [63:0] mask);
    int idx;
    idx = 0;
    for (int i = 63; i >= 0; i--) begin
      if (mask[i]) idx = i;
    end
    return idx;
  endfunction

  // inclusive window test shared by domain and guard checks
  function automatic logic in_win(input logic [63:0] v, input logic [63:0] lo,
                                  input logic [63:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/rdv_exec.sv
module rdv_exec
  import rdv_pkg::*;
#(
  parameter int N_MACH = 4,
  parameter int N_ENT  = 4,
  parameter int DW     = 8,
  parameter int IW     = 2,
  parameter logic [N_ENT*N_MACH-1:0] PART_MAP   = '0,
  parameter logic [N_ENT*IW-1:0]     PROD_MAP   = '0,
  parameter logic [N_ENT-1:0]        AGREE_MAP  = '0,
  parameter logic [N_ENT*DW-1:0]     DOM_LO_MAP = '0,
  parameter logic [N_ENT*DW-1:0]     DOM_HI_MAP = '0
) (
  input  logic [N_MACH*N_ENT-1:0]    req,
  input  logic [N_MACH*N_ENT*DW-1:0] val,
  input  logic [N_MACH*N_ENT*DW-1:0] grd_lo,
  input  logic [N_MACH*N_ENT*DW-1:0] grd_hi,
  output logic [N_ENT-1:0]           exe,
  output logic [N_ENT*DW-1:0]        xval
);

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    localparam logic [N_MACH-1:0] PART = PART_MAP[e*N_MACH +: N_MACH];
    localparam bit   AGREE = AGREE_MAP[e];
    localparam int   SRC   = AGREE ? low_bit(64'(PART)) : int'(PROD_MAP[e*IW +: IW]);
    localparam logic [DW-1:0] DLO = DOM_LO_MAP[e*DW +: DW];
    localparam logic [DW-1:0] DHI = DOM_HI_MAP[e*DW +: DW];

    logic          ok_c;
    logic [DW-1:0] v_c;

    always_comb begin
      v_c  = val[(SRC*N_ENT+e)*DW +: DW];
      ok_c = 1'b1;
      if (AGREE == 1'b0) begin
        if (!in_win(64'(v_c), 64'(DLO), 64'(DHI))) ok_c = 1'b0;
      end
      for (int m = 0; m < N_MACH; m++) begin
        if (PART[m]) begin
          if (!req[m*N_ENT+e]) ok_c = 1'b0;
          if (AGREE) begin
            if (val[(m*N_ENT+e)*DW +: DW] != v_c) ok_c = 1'b0;
          end else if (m != SRC) begin
            if (!in_win(64'(v_c), 64'(grd_lo[(m*N_ENT+e)*DW +: DW]),
                        64'(grd_hi[(m*N_ENT+e)*DW +: DW]))) ok_c = 1'b0;
          end
        end
      end
    end

    assign exe[e]             = ok_c;
    assign xval[e*DW +: DW]   = v_c;
  end

endmodule

// File: rtl/rdv_pick.sv
module rdv_pick #(
  parameter int N_MACH = 4,
  parameter int N_ENT  = 4,
  parameter logic [N_ENT*N_MACH-1:0] PART_MAP = '0,
  parameter logic [N_ENT*N_ENT-1:0]  CONF_MAP = '0,
  localparam int PW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ENT-1:0] exe,
  output logic [N_ENT-1:0] grant
);

  logic [N_ENT-1:0] cmask [N_ENT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_row
    for (genvar f = 0; f < N_ENT; f++) begin : g_col
      localparam bit SHARE = |(PART_MAP[e*N_MACH +: N_MACH] & PART_MAP[f*N_MACH +: N_MACH]);
      localparam bit LIST  = CONF_MAP[e*N_ENT+f] | CONF_MAP[f*N_ENT+e];
      assign cmask[e][f] = (e != f) && (SHARE || LIST);
    end
  end

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] first_idx;
  logic          first_v;

  always_comb begin
    grant     = '0;
    first_v   = 1'b0;
    first_idx = '0;
    for (int k = 0; k < N_ENT; k++) begin
      int e;
      e = int'(ptr_q) + k;
      if (e >= N_ENT) e = e - N_ENT;
      if (exe[e] && ((cmask[e] & grant) == '0)) begin
        grant[e] = 1'b1;
        if (!first_v) begin
          first_v   = 1'b1;
          first_idx = PW'(e);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (first_v) ptr_q <= (int'(first_idx) == N_ENT-1) ? '0 : first_idx + PW'(1);
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_chk
    p_no_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
      grant[e] |-> ((grant & cmask[e]) == '0));
    p_grant_exe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      grant[e] |-> exe[e]);
  end

  p_ptr_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exe == '0) |=> $stable(ptr_q));

endmodule

// File: rtl/rdv_route.sv
module rdv_route #(
  parameter int N_MACH = 4,
  parameter int N_ENT  = 4,
  parameter int DW     = 8,
  parameter logic [N_ENT*N_MACH-1:0] PART_MAP = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_ENT-1:0]     grant,
  input  logic [N_ENT*DW-1:0]  xval,
  input  logic [N_MACH-1:0]    solo_req,
  output logic [N_MACH-1:0]    fire,
  output logic [N_ENT-1:0]     ent_fire,
  output logic [N_MACH*DW-1:0] rx_data,
  output logic [N_MACH-1:0]    solo_fire
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_fire  <= '0;
      solo_fire <= '0;
    end else begin
      ent_fire  <= grant;
      solo_fire <= solo_req;
    end
  end

  for (genvar m = 0; m < N_MACH; m++) begin : g_mach
    logic          hit;
    logic [DW-1:0] dsel;

    always_comb begin
      hit  = 1'b0;
      dsel = '0;
      for (int e = 0; e < N_ENT; e++) begin
        if (grant[e] && PART_MAP[e*N_MACH+m]) begin
          hit  = 1'b1;
          dsel = xval[e*DW +: DW];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fire[m]              <= 1'b0;
        rx_data[m*DW +: DW]  <= '0;
      end else begin
        fire[m] <= hit;
        if (hit) rx_data[m*DW +: DW] <= dsel;
      end
    end

    p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !fire[m] |-> (rx_data[m*DW +: DW] == $past(rx_data[m*DW +: DW])));
  end

  p_solo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (solo_fire == $past(solo_req)));

endmodule

// File: rtl/rdv_arbiter.sv
module rdv_arbiter #(
  parameter int N_MACH = 4,
  parameter int N_ENT  = 4,
  parameter int DW     = 8,
  parameter logic [N_ENT*N_MACH-1:0] PART_MAP   = 16'hC369,
  parameter logic [N_ENT*2-1:0]      PROD_MAP   = 8'h84,
  parameter logic [N_ENT-1:0]        AGREE_MAP  = 4'b0100,
  parameter logic [N_ENT*N_ENT-1:0]  CONF_MAP   = 16'h0012,
  parameter logic [N_ENT*DW-1:0]     DOM_LO_MAP = 32'h0000_1000,
  parameter logic [N_ENT*DW-1:0]     DOM_HI_MAP = 32'h64FF_FFC8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_MACH*N_ENT-1:0]     req,
  input  logic [N_MACH*N_ENT*DW-1:0]  val,
  input  logic [N_MACH*N_ENT*DW-1:0]  grd_lo,
  input  logic [N_MACH*N_ENT*DW-1:0]  grd_hi,
  input  logic [N_MACH-1:0]           solo_req,
  output logic [N_MACH-1:0]           fire,
  output logic [N_ENT-1:0]            ent_fire,
  output logic [N_MACH*DW-1:0]        rx_data,
  output logic [N_MACH-1:0]           solo_fire
);

  localparam int IW = 2;

  logic [N_ENT-1:0]    exe;
  logic [N_ENT*DW-1:0] xval;
  logic [N_ENT-1:0]    grant;

  rdv_exec #(
    .N_MACH(N_MACH), .N_ENT(N_ENT), .DW(DW), .IW(IW),
    .PART_MAP(PART_MAP), .PROD_MAP(PROD_MAP), .AGREE_MAP(AGREE_MAP),
    .DOM_LO_MAP(DOM_LO_MAP), .DOM_HI_MAP(DOM_HI_MAP)
  ) u_exec (
    .req(req), .val(val), .grd_lo(grd_lo), .grd_hi(grd_hi),
    .exe(exe), .xval(xval)
  );

  rdv_pick #(
    .N_MACH(N_MACH), .N_ENT(N_ENT), .PART_MAP(PART_MAP), .CONF_MAP(CONF_MAP)
  ) u_pick (
    .clk(clk), .rst_n(rst_n), .exe(exe), .grant(grant)
  );

  rdv_route #(
    .N_MACH(N_MACH), .N_ENT(N_ENT), .DW(DW), .PART_MAP(PART_MAP)
  ) u_route (
    .clk(clk), .rst_n(rst_n), .grant(grant), .xval(xval), .solo_req(solo_req),
    .fire(fire), .ent_fire(ent_fire), .rx_data(rx_data), .solo_fire(solo_fire)
  );

  // per-machine request summary and participant columns for the checks
  logic [N_MACH-1:0] any_req;
  logic [N_ENT-1:0]  pcol [N_MACH];

  for (genvar m = 0; m < N_MACH; m++) begin : g_mchk
    assign any_req[m] = |req[m*N_ENT +: N_ENT];
    for (genvar e = 0; e < N_ENT; e++) begin : g_col
      assign pcol[m][e] = PART_MAP[e*N_MACH+m];
    end

    p_fire_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fire[m] |-> $past(any_req[m]));
    p_single_ent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ent_fire & pcol[m]) <= 1);
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_echk
    localparam logic [N_MACH-1:0] PART = PART_MAP[e*N_MACH +: N_MACH];
    p_fire_part_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ent_fire[e] |-> ((fire & PART) == PART));
  end

endmodule

// File: tb/rdv_arbiter_tb.sv
module rdv_arbiter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;
  localparam int NE = 4;
  localparam int DW = 8;
  localparam logic [NE*NM-1:0] PART_MAP   = 16'hC369;
  localparam logic [NE*2-1:0]  PROD_MAP   = 8'h84;
  localparam logic [NE-1:0]    AGREE_MAP  = 4'b0100;
  localparam logic [NE*NE-1:0] CONF_MAP   = 16'h0012;
  localparam logic [NE*DW-1:0] DOM_LO_MAP = 32'h0000_1000;
  localparam logic [NE*DW-1:0] DOM_HI_MAP = 32'h64FF_FFC8;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [NM*NE-1:0]       req = '0;
  logic [NM*NE*DW-1:0]    val = '0;
  logic [NM*NE*DW-1:0]    grd_lo = '0;
  logic [NM*NE*DW-1:0]    grd_hi = '0;
  logic [NM-1:0]          solo_req = '0;
  logic [NM-1:0]          fire;
  logic [NE-1:0]          ent_fire;
  logic [NM*DW-1:0]       rx_data;
  logic [NM-1:0]          solo_fire;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdv_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .val(val), .grd_lo(grd_lo), .grd_hi(grd_hi),
    .solo_req(solo_req), .fire(fire), .ent_fire(ent_fire), .rx_data(rx_data),
    .solo_fire(solo_fire)
  );

  // staged stimulus, applied at the falling edge
  logic [NM*NE-1:0]    s_req;
  logic [NM*NE*DW-1:0] s_val, s_lo, s_hi;
  logic [NM-1:0]       s_solo;

  typedef struct {
    logic [NE-1:0]    ent;
    logic [NM-1:0]    fire;
    logic [NM-1:0]    solo;
    logic [NM*DW-1:0] rx;
    string            tag;
  } exp_t;

  exp_t          sb[$];
  int            n_tests = 0;
  int            n_fail  = 0;
  int            mptr    = 0;
  logic [NM*DW-1:0] mrx  = '0;
  string         cur_tag = "R1";

  task automatic check(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clr();
    s_req = '0; s_val = '0; s_lo = '0; s_hi = '0; s_solo = '0;
  endtask

  task automatic put(input int m, input int e, input int v, input int lo, input int hi);
    s_req[m*NE+e] = 1'b1;
    s_val[(m*NE+e)*DW +: DW] = DW'(v);
    s_lo[(m*NE+e)*DW +: DW]  = DW'(lo);
    s_hi[(m*NE+e)*DW +: DW]  = DW'(hi);
  endtask

  function automatic bit conflicts(input int e, input int f);
    if (e == f) return 1'b0;
    if (CONF_MAP[e*NE+f] || CONF_MAP[f*NE+e]) return 1'b1;
    return |(PART_MAP[e*NM +: NM] & PART_MAP[f*NM +: NM]);
  endfunction

  // reference model of one cycle, from the requirements
  task automatic model(output exp_t x);
    logic [NE-1:0] exe, tk;
    logic [DW-1:0] xv [NE];
    int first;
    for (int e = 0; e < NE; e++) begin
      logic [NM-1:0] part;
      int src;
      bit ok;
      part = PART_MAP[e*NM +: NM];
      src = 0;
      if (AGREE_MAP[e]) begin
        for (int m = NM-1; m >= 0; m--) if (part[m]) src = m;
      end else src = int'(PROD_MAP[e*2 +: 2]);
      xv[e] = s_val[(src*NE+e)*DW +: DW];
      ok = 1'b1;
      if (!AGREE_MAP[e] && (xv[e] < DOM_LO_MAP[e*DW +: DW] || xv[e] > DOM_HI_MAP[e*DW +: DW]))
        ok = 1'b0;
      for (int m = 0; m < NM; m++) begin
        if (part[m]) begin
          if (!s_req[m*NE+e]) ok = 1'b0;
          if (AGREE_MAP[e]) begin
            if (s_val[(m*NE+e)*DW +: DW] != xv[e]) ok = 1'b0;
          end else if (m != src) begin
            if (xv[e] < s_lo[(m*NE+e)*DW +: DW] || xv[e] > s_hi[(m*NE+e)*DW +: DW]) ok = 1'b0;
          end
        end
      end
      exe[e] = ok;
    end
    tk = '0; first = -1;
    for (int k = 0; k < NE; k++) begin
      int e;
      bit clash;
      e = (mptr + k) % NE;
      clash = 1'b0;
      for (int f = 0; f < NE; f++) if (tk[f] && conflicts(e, f)) clash = 1'b1;
      if (exe[e] && !clash) begin
        tk[e] = 1'b1;
        if (first < 0) first = e;
      end
    end
    if (first >= 0) mptr = (first + 1) % NE;
    x.ent = tk; x.fire = '0;
    for (int e = 0; e < NE; e++) begin
      if (tk[e]) begin
        for (int m = 0; m < NM; m++) begin
          if (PART_MAP[e*NM+m]) begin
            x.fire[m] = 1'b1;
            mrx[m*DW +: DW] = xv[e];
          end
        end
      end
    end
    x.rx = mrx; x.solo = s_solo; x.tag = cur_tag;
  endtask

  task automatic step();
    exp_t x;
    @(negedge clk);
    req = s_req; val = s_val; grd_lo = s_lo; grd_hi = s_hi; solo_req = s_solo;
    model(x);
    sb.push_back(x);
  endtask

  // monitor: compares one result per cycle, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        check(x.tag, "ent_fire", 64'(ent_fire), 64'(x.ent));
        check(x.tag, "fire", 64'(fire), 64'(x.fire));
        check(x.tag, "rx_data", 64'(rx_data), 64'(x.rx));
        check("R9", "solo_fire", 64'(solo_fire), 64'(x.solo));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    #1;
    check("R1", "fire", 64'(fire), 0);
    check("R1", "ent_fire", 64'(ent_fire), 0);
    check("R1", "rx_data", 64'(rx_data), 0);
    check("R1", "solo_fire", 64'(solo_fire), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1/R8: e0 and e1 listed exclusive, pointer at 0 -> e0 wins first
    cur_tag = "R8";
    clr(); put(0,0,50,0,0); put(3,0,0,0,255); put(1,1,20,0,0); put(2,1,0,0,255); step();
    step(); step(); step();
    // R7: e0 and e3 share machine 3
    cur_tag = "R7";
    clr(); put(0,0,9,0,0); put(3,0,0,0,255); put(2,3,40,0,0); put(3,3,0,0,255); step(); step();
    // R7: e2 and e3 are disjoint -> fire together
    clr(); put(0,2,7,0,0); put(1,2,7,0,0); put(2,3,60,0,0); put(3,3,0,60,60); step();
    // R5: unequal agreement values
    cur_tag = "R5";
    clr(); put(0,2,7,0,0); put(1,2,8,0,0); step();
    // R2: missing participant
    cur_tag = "R2";
    clr(); put(0,0,33,0,0); step();
    clr(); put(3,0,0,0,255); step();
    // R3: domain edges of e0 (0..200) and e1 (16..255) and e3 (0..100)
    cur_tag = "R3";
    clr(); put(0,0,200,0,0); put(3,0,0,0,255); step();
    clr(); put(0,0,201,0,0); put(3,0,0,0,255); step();
    clr(); put(1,1,15,0,0); put(2,1,0,0,255); step();
    clr(); put(1,1,16,0,0); put(2,1,0,0,255); step();
    clr(); put(2,3,101,0,0); put(3,3,0,0,255); step();
    // R4: guard edges
    cur_tag = "R4";
    clr(); put(1,1,20,0,0); put(2,1,0,30,40); step();
    clr(); put(1,1,30,0,0); put(2,1,0,30,40); step();
    clr(); put(1,1,41,0,0); put(2,1,0,30,40); step();
    clr(); put(1,1,40,0,0); put(2,1,0,30,40); step();
    // R6: hold with no fire
    cur_tag = "R6";
    clr(); step(); step();
    // R9: solo requests during arbitration
    cur_tag = "R9";
    clr(); s_solo = 4'b1010; put(0,2,3,0,0); put(1,2,3,0,0); step();
    clr(); s_solo = 4'b0101; step();
    clr(); step();
    // random phase against the model
    cur_tag = "R7/R8 random";
    for (int i = 0; i < 400; i++) begin
      clr();
      for (int m = 0; m < NM; m++) begin
        for (int e = 0; e < NE; e++) begin
          if ($urandom_range(0, 2) != 0) begin
            int lo;
            lo = $urandom_range(0, 150);
            put(m, e, (e == 2) ? $urandom_range(5, 6) : $urandom_range(0, 220),
                lo, lo + $urandom_range(0, 105));
          end
        end
      end
      s_solo = NM'($urandom);
      step();
    end
    clr(); step();
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule